// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block drives the command lines of an SDRAM array from power-up until a controller core can take over, and afterwards keeps the array refreshed. Once reset is released it holds the bus idle for a long stabilisation pause and then closes every bank with a precharge-all command. It follows this with eight auto-refresh commands and finally programs the mode register. Each of these commands is separated from the next by the device's minimum spacing. The spacings are given as times and converted to whole clock cycles, rounding up, from a parameter that states how many clocks fit in one microsecond.

When the mode register delay has elapsed the block raises `initDone` and starts a free-running refresh interval timer. The interval is 7.8 µs for arrays with 8k rows and 15.6 µs for arrays with 4k rows. Each expiry adds one to an owed-refresh count. While refreshes are owed and the sequencer is idle it raises `refReq`. The controller answers with `refGrant` once it has the bus free, and the sequencer then emits the auto-refresh command on the following cycle. The block drives one command per clock and an address word. The address word carries the all-banks bit during a precharge and the mode value during a mode-register write.

Top module: `sdr_bringup_seq`

## Requirements
- R1: After reset the command output is NOP (code 0), and `initDone` and `refReq` are low, for exactly PAUSE_US × CLK_PER_US cycles.
- R2: The first command after the pause is precharge-all (code 1). It is driven with address bit 10 set and every other address bit clear.
- R3: Exactly eight auto-refresh commands (code 2) are issued after the precharge, and the next command after them is the mode-register write (code 3).
- R4: The first refresh comes TRP cycles after the precharge. Each command that follows an auto-refresh comes TRC cycles after it. NOP is driven on every cycle in between. A time t is converted to cycles as ceil(t × CLK_PER_US / 1 µs), with a floor of 2.
- R5: The mode-register write drives MODE_VAL on the address output.
- R6: `initDone` rises exactly MRD_CYC cycles after the mode-register write cycle, and stays high until reset.
- R7: `refReq` first rises exactly REFI cycles after `initDone` rises. REFI is ceil(7.8 µs) in cycles when ROW_8K=1 and ceil(15.6 µs) in cycles when ROW_8K=0.
- R8: Once raised, `refReq` stays high and no command is issued until `refGrant` is seen.
- R9: A grant sampled while `refReq` is high produces an auto-refresh on the next cycle. `refReq` then stays low until TRC cycles after that refresh. A grant while `refReq` is low has no effect.
- R10: The interval timer keeps running while a request waits. Expiries accumulate, saturating at 2^OWED_W−1, and each one needs its own grant. Expiries fall at fixed multiples of REFI after `initDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Controller permits the pending refresh |
| cmd | output | 2 | Command: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode-register write |
| addr | output | ADDR_W | Address word: bit 10 on precharge, MODE_VAL on mode write, else zero |
| initDone | output | 1 | Bring-up finished; controller may operate |
| refReq | output | 1 | At least one refresh owed and sequencer idle |

## Verification
On every cycle the assertions check several properties. Each non-NOP command is followed by a NOP, and the mode write only appears once eight start-up refreshes are counted. `initDone` never falls, `refReq` is never seen before bring-up ends, and every post-init refresh traces back to a request and grant. The owed count neither wraps nor is drawn down when empty. The exact cycle distances can only be shown by the bench scenarios. Those are the pause length, the precharge-to-refresh and refresh-to-refresh spacing, the mode-write-to-done delay, and the two interval lengths. The bench scenarios also show that held requests accumulate without losing an interval, and that a stray grant is ignored.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP           = 2'd0,
    CMD_PRECHARGE_ALL = 2'd1,
    CMD_AUTO_REFRESH  = 2'd2,
    CMD_MODE_SET      = 2'd3
  } sdrCmd_t;

  // which spacing the shared gap counter is loaded with
  typedef enum logic [1:0] {
    GAP_TRP = 2'd0,
    GAP_TRC = 2'd1,
    GAP_MRD = 2'd2
  } gapSel_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic    loadGap;
    gapSel_t gapSel;
    logic    runGap;
    logic    bumpInitRef;
    logic    startRefi;
    logic    takeRefresh;
  } seqStrobe_t;

  // time in units of 1/unitsPerUs microseconds -> clocks, rounded up
  function automatic int unsigned ceilCycles(int unsigned timeVal,
                                             int unsigned perUs,
                                             int unsigned unitsPerUs);
    return (timeVal * perUs + unitsPerUs - 1) / unitsPerUs;
  endfunction

  // a spacing below two clocks is not representable by the wait states
  function automatic int unsigned atLeastTwo(int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

endpackage

// File: rtl/sdr_seq_timers.sv
module sdr_seq_timers
  import sdr_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 13300,
  parameter int unsigned TRP_CYC   = 3,
  parameter int unsigned TRC_CYC   = 9,
  parameter int unsigned MRD_GAP   = 2,
  parameter int unsigned REFI_CYC  = 1038,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned OWED_W    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       gapDone,
  output logic       initRefsDone,
  output logic       refOwed
);

  localparam int unsigned GAP_W  = $clog2(PAUSE_CYC + TRP_CYC + TRC_CYC + MRD_GAP + 1);
  localparam int unsigned REFI_W = $clog2(REFI_CYC + 1);
  localparam int unsigned IREF_W = $clog2(INIT_REFS + 1);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  logic [GAP_W-1:0]  gapCnt;
  logic [IREF_W-1:0] initRefCnt;
  logic [REFI_W-1:0] refiCnt;
  logic              refiRunning;
  logic              refiExpire;
  logic [OWED_W-1:0] owedCnt;
  logic [GAP_W-1:0]  gapLoadVal;

  // shared spacing counter: one cycle of the issuing state plus (gap-1) waits
  always_comb begin
    case (strobe.gapSel)
      GAP_TRP: gapLoadVal = GAP_W'(TRP_CYC - 2);
      GAP_TRC: gapLoadVal = GAP_W'(TRC_CYC - 2);
      default: gapLoadVal = GAP_W'(MRD_GAP - 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= GAP_W'(PAUSE_CYC - 1);
    end else if (strobe.loadGap) begin
      gapCnt <= gapLoadVal;
    end else if (strobe.runGap && gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initRefCnt <= '0;
    end else if (strobe.bumpInitRef && initRefCnt != IREF_W'(INIT_REFS)) begin
      initRefCnt <= initRefCnt + 1'b1;
    end
  end

  assign initRefsDone = (initRefCnt == IREF_W'(INIT_REFS));

  // free-running interval timer, started once bring-up ends
  assign refiExpire = refiRunning && (refiCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refiRunning <= 1'b0;
      refiCnt     <= '0;
    end else if (strobe.startRefi) begin
      refiRunning <= 1'b1;
      refiCnt     <= REFI_W'(REFI_CYC - 1);
    end else if (refiRunning) begin
      refiCnt <= refiExpire ? REFI_W'(REFI_CYC - 1) : refiCnt - 1'b1;
    end
  end

  // owed refreshes: expiries add, grants subtract
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owedCnt <= '0;
    end else begin
      case ({refiExpire, strobe.takeRefresh})
        2'b10:   if (owedCnt != OWED_MAX) owedCnt <= owedCnt + 1'b1;
        2'b01:   owedCnt <= owedCnt - 1'b1;
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  assign refOwed = (owedCnt != '0);

  AST_OWED_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (owedCnt == OWED_MAX && refiExpire && !strobe.takeRefresh) |=> owedCnt == OWED_MAX); // R10

  AST_TAKE_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRefresh |-> owedCnt != '0); // R8

  AST_GAP_IDLE_DURING_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGap |-> gapDone); // R4

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned MODE_VAL = 'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGrant,
  input  logic              gapDone,
  input  logic              initRefsDone,
  input  logic              refOwed,
  output seqStrobe_t        strobe,
  output sdrCmd_t           cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refReq
);

  localparam int unsigned      ALL_BANKS_BIT = 10;
  localparam logic [ADDR_W-1:0] ALL_BANKS_MASK = ADDR_W'(1) << ALL_BANKS_BIT;
  localparam logic [ADDR_W-1:0] MODE_BITS      = ADDR_W'(MODE_VAL);

  typedef enum logic [3:0] {
    S_PAUSE, S_PRE, S_TRP_WAIT, S_INIT_REF, S_INIT_TRC,
    S_MODE, S_MRD_WAIT, S_IDLE, S_RUN_REF, S_RUN_TRC
  } seqState_t;

  seqState_t state, nextState;
  logic      setDone;
  logic      initDoneQ;

  always_comb begin
    nextState = state;
    strobe    = '0;
    cmd       = CMD_NOP;
    addr      = '0;
    setDone   = 1'b0;
    case (state)
      S_PAUSE: begin
        strobe.runGap = 1'b1;
        if (gapDone) nextState = S_PRE;
      end
      S_PRE: begin
        cmd            = CMD_PRECHARGE_ALL;
        addr           = ALL_BANKS_MASK;
        strobe.loadGap = 1'b1;
        strobe.gapSel  = GAP_TRP;
        nextState      = S_TRP_WAIT;
      end
      S_TRP_WAIT: begin
        strobe.runGap = 1'b1;
        if (gapDone) nextState = S_INIT_REF;
      end
      S_INIT_REF: begin
        cmd                = CMD_AUTO_REFRESH;
        strobe.loadGap     = 1'b1;
        strobe.gapSel      = GAP_TRC;
        strobe.bumpInitRef = 1'b1;
        nextState          = S_INIT_TRC;
      end
      S_INIT_TRC: begin
        strobe.runGap = 1'b1;
        if (gapDone) nextState = initRefsDone ? S_MODE : S_INIT_REF;
      end
      S_MODE: begin
        cmd            = CMD_MODE_SET;
        addr           = MODE_BITS;
        strobe.loadGap = 1'b1;
        strobe.gapSel  = GAP_MRD;
        nextState      = S_MRD_WAIT;
      end
      S_MRD_WAIT: begin
        strobe.runGap = 1'b1;
        if (gapDone) begin
          strobe.startRefi = 1'b1;
          setDone          = 1'b1;
          nextState        = S_IDLE;
        end
      end
      S_IDLE: begin
        if (refOwed && refGrant) begin
          strobe.takeRefresh = 1'b1;
          nextState          = S_RUN_REF;
        end
      end
      S_RUN_REF: begin
        cmd            = CMD_AUTO_REFRESH;
        strobe.loadGap = 1'b1;
        strobe.gapSel  = GAP_TRC;
        nextState      = S_RUN_TRC;
      end
      S_RUN_TRC: begin
        strobe.runGap = 1'b1;
        if (gapDone) nextState = S_IDLE;
      end
      default: nextState = S_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_PAUSE;
      initDoneQ <= 1'b0;
    end else begin
      state <= nextState;
      if (setDone) initDoneQ <= 1'b1;
    end
  end

  assign initDone = initDoneQ;
  assign refReq   = (state == S_IDLE) && refOwed;

  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R4

  AST_MODE_AFTER_REFS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_MODE_SET) |-> initRefsDone); // R3

  AST_PRE_BEFORE_REFS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRECHARGE_ALL) |-> (!initRefsDone && !initDone)); // R2

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R6

  AST_REQ_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> initDone); // R7

  AST_REFRESH_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_AUTO_REFRESH && initDone) |-> $past(refReq && refGrant)); // R9

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 133,
  parameter int unsigned PAUSE_US   = 100,
  parameter int unsigned TRP_PS     = 20000,
  parameter int unsigned TRC_PS     = 67500,
  parameter int unsigned MRD_CYC    = 2,
  parameter bit          ROW_8K     = 1'b1,
  parameter int unsigned INIT_REFS  = 8,
  parameter int unsigned OWED_W     = 3,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned MODE_VAL   = 'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGrant,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refReq
);

  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_PER_US;
  localparam int unsigned TRP_CYC   = atLeastTwo(ceilCycles(TRP_PS, CLK_PER_US, 1000000));
  localparam int unsigned TRC_CYC   = atLeastTwo(ceilCycles(TRC_PS, CLK_PER_US, 1000000));
  localparam int unsigned MRD_GAP   = atLeastTwo(MRD_CYC);
  localparam int unsigned REFI_NS   = ROW_8K ? 7800 : 15600;
  localparam int unsigned REFI_CYC  = ceilCycles(REFI_NS, CLK_PER_US, 1000);

  seqStrobe_t strobe;
  sdrCmd_t    cmdEnum;
  logic       gapDone;
  logic       initRefsDone;
  logic       refOwed;

  sdr_seq_ctrl #(
    .ADDR_W   (ADDR_W),
    .MODE_VAL (MODE_VAL)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .refGrant     (refGrant),
    .gapDone      (gapDone),
    .initRefsDone (initRefsDone),
    .refOwed      (refOwed),
    .strobe       (strobe),
    .cmd          (cmdEnum),
    .addr         (addr),
    .initDone     (initDone),
    .refReq       (refReq)
  );

  sdr_seq_timers #(
    .PAUSE_CYC (PAUSE_CYC),
    .TRP_CYC   (TRP_CYC),
    .TRC_CYC   (TRC_CYC),
    .MRD_GAP   (MRD_GAP),
    .REFI_CYC  (REFI_CYC),
    .INIT_REFS (INIT_REFS),
    .OWED_W    (OWED_W)
  ) u_timers (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .gapDone      (gapDone),
    .initRefsDone (initRefsDone),
    .refOwed      (refOwed)
  );

  assign cmd = cmdEnum;

endmodule

// File: tb/sdr_bringup_seq_tb.sv
`timescale 1ns/1ps
module sdr_bringup_seq_tb;

  localparam int CPU       = 200;
  localparam int PAUSE     = 100 * CPU;
  localparam int TRP       = (20000 * CPU + 999999) / 1000000;
  localparam int TRC       = (67500 * CPU + 999999) / 1000000;
  localparam int MRD       = 2;
  localparam int REFI_FAST = (7800 * CPU + 999) / 1000;
  localparam int REFI_SLOW = (15600 * CPU + 999) / 1000;
  localparam int MODEV     = 'h032;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refGrant = 1'b0;
  logic [1:0]  cmd, cmd2;
  logic [12:0] addr, addr2;
  logic        initDone, refReq, initDone2, refReq2;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  int dInit = 0;
  int slowInit = -1;
  int slowReq = -1;

  always #2.5 clk = ~clk;

  sdr_bringup_seq #(.CLK_PER_US(CPU), .ROW_8K(1'b1), .MODE_VAL(MODEV)) u_dut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .cmd(cmd), .addr(addr), .initDone(initDone), .refReq(refReq));

  sdr_bringup_seq #(.CLK_PER_US(CPU), .ROW_8K(1'b0), .MODE_VAL(MODEV)) u_dut_slow (
    .clk(clk), .rstN(rstN), .refGrant(1'b0),
    .cmd(cmd2), .addr(addr2), .initDone(initDone2), .refReq(refReq2));

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (initDone2 && slowInit < 0) slowInit = cyc;
      if (refReq2 && slowReq < 0)   slowReq = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic nextCmd(output int at);
    int guard = 0;
    step();
    while (cmd == 2'd0 && guard < 1000) begin
      guard++;
      step();
    end
    at = cyc;
  endtask

  task automatic t_reset();
    repeat (3) step();
    check(cmd == 2'd0, "R1", "cmd in reset", cmd, 0);
    check(!initDone && !refReq, "R1", "flags in reset", {initDone, refReq}, 0);
    rstN = 1'b1;
    step();
    check(cmd == 2'd0 && cyc == 1, "R1", "cmd after release", cmd, 0);
  endtask

  task automatic t_bringup();
    int p, at, prev;
    bit quiet = 1'b1;
    while (cmd == 2'd0 && cyc < PAUSE + 10) begin
      if (initDone || refReq) quiet = 1'b0;
      step();
    end
    check(quiet, "R1", "flags low in pause", 0, 1);
    check(cyc == PAUSE, "R1", "pause length", cyc, PAUSE);
    check(cmd == 2'd1, "R2", "first command", cmd, 1);
    check(int'(addr) == (1 << 10), "R2", "precharge address", addr, 1 << 10);
    p = cyc;
    nextCmd(at);
    check(at - p == TRP, "R4", "precharge to refresh", at - p, TRP);
    check(cmd == 2'd2, "R3", "refresh 1", cmd, 2);
    prev = at;
    for (int i = 2; i <= 8; i++) begin
      nextCmd(at);
      check(at - prev == TRC && cmd == 2'd2, "R4", "refresh spacing", at - prev, TRC);
      prev = at;
    end
    nextCmd(at);
    check(cmd == 2'd3, "R3", "command after eight refreshes", cmd, 3);
    check(at - prev == TRC, "R4", "refresh to mode write", at - prev, TRC);
    check(int'(addr) == MODEV, "R5", "mode value", addr, MODEV);
    step();
    check(!initDone, "R6", "initDone one cycle after mode write", initDone, 0);
    step();
    check(initDone && cyc == at + MRD, "R6", "initDone at MRD", cyc - at, MRD);
    dInit = cyc;
  endtask

  task automatic t_stray_grant();
    bit ok = 1'b1;
    repeat (100) step();
    refGrant = 1'b1;
    repeat (5) begin
      step();
      if (cmd != 2'd0 || refReq) ok = 1'b0;
    end
    refGrant = 1'b0;
    check(ok, "R9", "grant without request ignored", cmd, 0);
  endtask

  task automatic t_interval();
    bit held = 1'b1;
    int g;
    while (cyc < dInit + REFI_FAST - 1) step();
    check(!refReq, "R7", "refReq before interval", refReq, 0);
    step();
    check(refReq, "R7", "refReq at interval", cyc - dInit, REFI_FAST);
    while (cyc < dInit + 2 * REFI_FAST + 5) begin
      step();
      if (!refReq || cmd != 2'd0) held = 1'b0;
    end
    check(held, "R8", "request held without grant", refReq, 1);
    g = cyc;
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    check(cmd == 2'd2 && !refReq, "R9", "refresh after grant", cmd, 2);
    while (cyc < g + TRC) begin
      step();
      if (refReq) held = 1'b0;
    end
    check(held, "R9", "refReq low during TRC", refReq, 0);
    step();
    check(refReq, "R10", "second owed refresh kept", refReq, 1);
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    check(cmd == 2'd2, "R10", "second grant refreshes", cmd, 2);
    repeat (TRC) step();
    check(!refReq, "R10", "owed count drained", refReq, 0);
    while (cyc < dInit + 3 * REFI_FAST - 1) step();
    check(!refReq, "R10", "before third expiry", refReq, 0);
    step();
    check(refReq, "R10", "third expiry on schedule", cyc - dInit, 3 * REFI_FAST);
    refGrant = 1'b1;
    step();
    refGrant = 1'b0;
    check(cmd == 2'd2, "R9", "refresh after third grant", cmd, 2);
  endtask

  task automatic t_slow();
    while (slowReq < 0 && cyc < dInit + 2 * REFI_SLOW) step();
    check(slowReq - slowInit == REFI_SLOW, "R7", "4k-row interval", slowReq - slowInit, REFI_SLOW);
    check(initDone, "R6", "initDone still high", initDone, 1);
  endtask

  initial begin
    t_reset();
    t_bringup();
    t_stray_grant();
    t_interval();
    t_slow();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 5.0);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule